// File: doc/BRIEF.md
# Configuration Space Target

This block is the bus-target side of a single-function device's configuration space. It watches the shared bus for a Type 0 configuration address phase selected by the device-select line, takes a DWord register index from the address, and then serves exactly one data phase with a fixed schedule. It asserts the device-select response with medium decode timing and asserts target-ready on the third clock of the data phase. For reads it drives the selected register onto the data lines. For writes it merges the data lanes picked by the byte enables into the register file.

The target never takes part in a burst. An initiator that holds the frame line low into the third data clock gets a disconnect. While an external status input reports that nonvolatile configuration is still being loaded after reset, any access that hits the target ends in a retry and leaves the registers untouched. The select, ready and stop outputs are sustained three-state signals. Each comes with an output enable, and all three are driven high for one clock before being released. The target recognises an address phase that follows the final data phase of any transaction with no idle clock between them, including the turnaround clock of its own previous access.

Top module: `cfg_space_target`

## Requirements
- R1: The target responds only when, in the address phase, IDSEL is high, AD[1:0] is 00 and C/BE#[3:0] is 1010 (read) or 1011 (write). Any other address phase leaves DEVSEL#, TRDY# and STOP# undriven and changes no register.
- R2: The register index is AD[7:2] of the address phase. AD[31:8] have no effect on which register is accessed.
- R3: DEVSEL# goes low in the second clock after the address-phase edge. It is still high in the clock right after that edge.
- R4: TRDY# goes low one clock after DEVSEL#, which is the third data-phase clock. It stays low until IRDY# is sampled low. During that window a read drives AD (ad_oe high) with the selected register.
- R5: On a write, data-phase C/BE#[n] low updates byte lane AD[8n+7:8n] and C/BE#[n] high preserves that lane. This gives 8-, 16- and 32-bit writes.
- R6: Register map:
  - Index 0 reads the ID_WORD parameter and ignores writes.
  - Index 1 has a writable command half in bits 15:0. Its bits 31:16 read 0x0080, so bit 23 (fast back-to-back capable) is always 1.
  - Indices 2 to NREGS-1 are writable and reset to 0.
  - Indices NREGS to 63 read 0 and ignore writes.
- R7: If FRAME# is still low at the edge where DEVSEL# first reads low, STOP# is asserted together with TRDY#. If FRAME# is still low when the data phase completes, STOP# and DEVSEL# stay low with TRDY# high until FRAME# is sampled high.
- R8: If the loading input is high in the address phase, the target asserts DEVSEL# and STOP# with TRDY# high (retry), does not drive AD, and performs no write.
- R9: After every claimed transaction, DEVSEL#, TRDY# and STOP# are driven high for exactly one clock and are then released (ctl_oe low).
- R10: An address phase is detected when FRAME# is sampled low after being sampled high. This holds even when the preceding clock was the last data phase of another transaction or the target's own turnaround clock.
- R11: In and directly after reset, no output enable is active and DEVSEL#, TRDY# and STOP# read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Initiator frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration device select |
| cbe_n | input | 4 | Command in address phase, byte enables (active low) in data phase |
| ad_in | input | 32 | Address/data lines as seen by the target |
| eeprom_busy | input | 1 | High while nonvolatile configuration is being loaded |
| ad_out | output | 32 | Read data for the AD lines |
| ad_oe | output | 1 | Enable for ad_out |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop, active low |
| ctl_oe | output | 1 | Enable shared by devsel_n, trdy_n and stop_n |

## Verification
The bench builds the target with NREGS at 8, so that a sweep over all 64 indices covers the ID word, the command/status word, the writable range and the unimplemented range that reads zero. Each write in the sweep uses a different byte-enable pattern, varies the ignored upper address bits, and cycles through single, disconnected and held-stop terminations, some issued back to back. Every read is compared with a model kept arithmetically in the bench. All sixteen byte-enable patterns, the retry window and the rejected address phases are then checked at the pins.

// File: rtl/cfg_space_target.sv
module cfg_space_target #(
  parameter int          NREGS   = 16,
  parameter logic [31:0] ID_WORD = 32'h5A17_0C3D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  input  logic        eeprom_busy,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n,
  output logic        ctl_oe
);
  localparam int IW = 6;
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_DEVS, S_DATA, S_HOLD, S_TURN} st_t;

  st_t           state;
  logic          frame_q, is_wr, retry, disc;
  logic [IW-1:0] idx;
  logic [15:0]   cmd_q;
  logic [31:0]   store [NREGS];
  logic [31:0]   rd;
  logic          addr_hit, in_range;

  assign addr_hit = frame_q && !frame_n && idsel && (ad_in[1:0] == 2'b00) && (cbe_n[3:1] == 3'b101);
  assign in_range = ({1'b0, idx} < 7'(NREGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      frame_q <= 1'b1;
      idx     <= '0;
      is_wr   <= 1'b0;
      retry   <= 1'b0;
      disc    <= 1'b0;
      cmd_q   <= '0;
      for (int i = 0; i < NREGS; i++) store[i] <= '0;
    end else begin
      frame_q <= frame_n;
      case (state)
        S_IDLE, S_TURN: begin
          if (addr_hit) begin
            state <= S_DEC;
            idx   <= ad_in[7:2];
            is_wr <= cbe_n[0];
            retry <= eeprom_busy;
          end else begin
            state <= S_IDLE;
          end
        end
        S_DEC:  state <= S_DEVS;
        S_DEVS: begin
          disc  <= !frame_n;
          state <= retry ? S_HOLD : S_DATA;
        end
        S_DATA: begin
          if (!irdy_n) begin
            state <= frame_n ? S_TURN : S_HOLD;
            if (is_wr) begin
              for (int b = 0; b < 4; b++) begin
                if (!cbe_n[b]) begin
                  if (idx == IW'(1) && b < 2)
                    cmd_q[8*b +: 8] <= ad_in[8*b +: 8];
                  else if (idx > IW'(1) && in_range)
                    store[idx[AW-1:0]][8*b +: 8] <= ad_in[8*b +: 8];
                end
              end
            end
          end
        end
        S_HOLD: if (frame_n) state <= S_TURN;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd = '0;
    if (idx == '0)          rd = ID_WORD;
    else if (idx == IW'(1)) rd = {16'h0080, cmd_q};
    else if (in_range)      rd = store[idx[AW-1:0]];
  end

  assign ad_out   = rd;
  assign ad_oe    = (state == S_DATA) && !is_wr;
  assign devsel_n = !(state == S_DEVS || state == S_DATA || state == S_HOLD);
  assign trdy_n   = !(state == S_DATA);
  assign stop_n   = !(state == S_HOLD || (state == S_DATA && disc));
  assign ctl_oe   = (state == S_DEVS || state == S_DATA || state == S_HOLD || state == S_TURN);

  p_medium_devsel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(frame_n, 2) == 1'b0);
  p_trdy_after_devsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n) |-> $past(!devsel_n) && !devsel_n);
  p_ad_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !trdy_n && !devsel_n);
  p_stop_inside_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> !devsel_n && ctl_oe);
  p_retry_no_trdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stop_n) && trdy_n) |=> trdy_n);
  p_release_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_oe) |-> $past(devsel_n && trdy_n && stop_n));
  p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_oe |-> devsel_n && trdy_n && stop_n && !ad_oe);
endmodule

// File: tb/test_cfg_space_target.sv
`timescale 1ns/1ps
module test_cfg_space_target;
  localparam int          NR = 8;
  localparam logic [31:0] IDW = 32'h5A17_0C3D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, eeprom_busy = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic ad_oe, devsel_n, trdy_n, stop_n, ctl_oe;
  int checks = 0, fails = 0;
  logic [31:0] exp_m [64];

  always #2 clk = ~clk;

  cfg_space_target #(.NREGS(NR), .ID_WORD(IDW)) i_cfg_space_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .eeprom_busy(eeprom_busy), .ad_out(ad_out),
    .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // order {devsel_n, trdy_n, stop_n, ctl_oe, ad_oe}
  task automatic sig(input string req, input logic [4:0] e);
    chk(req, {27'd0, devsel_n, trdy_n, stop_n, ctl_oe, ad_oe}, {27'd0, e});
  endtask

  function automatic void upd(int i, logic [3:0] ben, logic [31:0] wd);
    if (i == 0 || i >= NR) return;
    for (int b = 0; b < 4; b++)
      if (!ben[b] && (i != 1 || b < 2)) exp_m[i][8*b +: 8] = wd[8*b +: 8];
  endfunction

  // mode 0 single, 1 burst then frame raised, 2 burst with frame held past completion
  task automatic xact(input logic [31:0] addr, input logic [3:0] cmd, input logic id,
                      input logic [3:0] ben, input logic [31:0] wd, input int mode,
                      input logic load, input logic resp, input logic b2b,
                      output logic [31:0] rd);
    rd = '0;
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd; idsel = id; eeprom_busy = load;
    @(posedge clk); @(negedge clk);
    frame_n = (mode == 0); irdy_n = 1'b0; cbe_n = ben; ad_in = wd; idsel = 1'b0; eeprom_busy = 1'b0;
    sig("R3 early", 5'b11100);
    @(posedge clk); @(negedge clk);
    if (!resp) begin
      sig("R1 no claim", 5'b11100);
      frame_n = 1'b1;
      @(posedge clk); @(negedge clk);
      irdy_n = 1'b1;
      sig("R1 no claim", 5'b11100);
      @(posedge clk); @(negedge clk);
      return;
    end
    sig("R3 devsel", 5'b01110);
    @(posedge clk); @(negedge clk);
    if (load) begin
      sig("R8 retry", 5'b01010);
      frame_n = 1'b1;
      @(posedge clk); @(negedge clk);
    end else begin
      sig("R4 R7 data", {1'b0, 1'b0, mode == 0, 1'b1, !cmd[0]});
      if (!cmd[0]) rd = ad_out;
      if (mode == 1) frame_n = 1'b1;
      @(posedge clk); @(negedge clk);
      if (mode == 2) begin
        sig("R7 hold", 5'b01010);
        frame_n = 1'b1; irdy_n = 1'b1;
        @(posedge clk); @(negedge clk);
      end
    end
    irdy_n = 1'b1;
    sig("R9 turn", 5'b11110);
    if (!b2b) begin
      @(posedge clk); @(negedge clk);
      sig("R9 release", 5'b11100);
    end
  endtask

  function automatic logic [31:0] mkaddr(int i, int salt);
    return {21'(i * 37 + salt * 1001 + 5), 3'(i + salt), 6'(i), 2'b00};
  endfunction

  task automatic rd_chk(input int i, input string req);
    logic [31:0] r;
    xact(mkaddr(i, 3), 4'b1010, 1'b1, 4'h0, 32'h0, 0, 1'b0, 1'b1, 1'b0, r);
    chk(req, r, exp_m[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 64; i++) exp_m[i] = '0;
    exp_m[0] = IDW;
    exp_m[1] = 32'h0080_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    sig("R11 in reset", 5'b11100);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    sig("R11 after reset", 5'b11100);

    for (int i = 0; i < 64; i++) rd_chk(i, "R6 R11 reset value");

    for (int i = 0; i < 64; i++) begin
      logic [31:0] wd = 32'hA5C3_0F96 ^ (32'(i) * 32'h0101_0111);
      xact(mkaddr(i, i), 4'b1011, 1'b1, 4'(i * 7), wd, i % 3, 1'b0, 1'b1, (i % 4) == 0, r);
      upd(i, 4'(i * 7), wd);
    end
    for (int i = 0; i < 64; i++) rd_chk(i, "R2 R5 R6 sweep");

    for (int be = 0; be < 16; be++) begin
      logic [31:0] wd = 32'h1122_3344 * 32'(be + 1);
      xact(mkaddr(4, be), 4'b1011, 1'b1, 4'(be), wd, 0, 1'b0, 1'b1, 1'b0, r);
      upd(4, 4'(be), wd);
      rd_chk(4, "R5 byte enables");
    end

    xact(mkaddr(1, 9), 4'b1011, 1'b1, 4'h0, 32'hFFFF_FFFF, 0, 1'b0, 1'b1, 1'b0, r);
    upd(1, 4'h0, 32'hFFFF_FFFF);
    xact(mkaddr(1, 2), 4'b1010, 1'b1, 4'h0, 32'h0, 1, 1'b0, 1'b1, 1'b0, r);
    chk("R6 status word", r, 32'h0080_FFFF);
    chk("R6 fast b2b bit", {31'd0, r[23]}, 32'd1);
    xact(mkaddr(0, 4), 4'b1011, 1'b1, 4'h0, 32'h0, 0, 1'b0, 1'b1, 1'b0, r);
    rd_chk(0, "R6 id read-only");

    xact(mkaddr(5, 1), 4'b1011, 1'b0, 4'h0, 32'hDEAD_0001, 0, 1'b0, 1'b0, 1'b0, r);
    rd_chk(5, "R1 idsel low");
    xact(mkaddr(5, 1), 4'b0111, 1'b1, 4'h0, 32'hDEAD_0002, 0, 1'b0, 1'b0, 1'b0, r);
    rd_chk(5, "R1 wrong command");
    xact(mkaddr(5, 1) | 32'h1, 4'b1011, 1'b1, 4'h0, 32'hDEAD_0003, 0, 1'b0, 1'b0, 1'b0, r);
    rd_chk(5, "R1 type1 address");
    xact(mkaddr(5, 1), 4'b1110, 1'b1, 4'h0, 32'h0, 0, 1'b0, 1'b0, 1'b0, r);

    xact(mkaddr(6, 5), 4'b1011, 1'b1, 4'h0, 32'hBEEF_0006, 0, 1'b1, 1'b1, 1'b0, r);
    rd_chk(6, "R8 retry no write");
    xact(mkaddr(6, 5), 4'b1010, 1'b1, 4'h0, 32'h0, 0, 1'b1, 1'b1, 1'b1, r);
    xact(mkaddr(7, 2), 4'b1011, 1'b1, 4'h0, 32'h7777_0007, 0, 1'b0, 1'b1, 1'b0, r);
    upd(7, 4'h0, 32'h7777_0007);
    rd_chk(7, "R10 after own turnaround");

    frame_n = 1'b0; irdy_n = 1'b1; idsel = 1'b0; cbe_n = 4'b0110; ad_in = 32'h8000_0000;
    @(posedge clk); @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0;
    @(posedge clk); @(negedge clk);
    xact(mkaddr(3, 6), 4'b1011, 1'b1, 4'h0, 32'h3030_C0C0, 0, 1'b0, 1'b1, 1'b0, r);
    upd(3, 4'h0, 32'h3030_C0C0);
    rd_chk(3, "R10 after foreign phase");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule